// File: doc/BRIEF.md
# Command Queue Instruction Sequencer

This block steps through a program of 64-bit command words held in a local instruction memory. It executes them one at a time and turns them into register traffic on a simple request/acknowledge master port. The command set covers several operations. Plain and masked writes target a subsystem window. A read or write can use an address held in a general register. A poll re-reads a location until a masked compare succeeds. A wait-for-event instruction can block on, set or clear hardware event flags. Arithmetic and logic operations work on a 16-entry register file. Jumps can be relative or absolute, and an end-of-command instruction stops the engine and may raise an interrupt.

Software loads the program through the memory write port and pulses `start`. Execution begins at word 0. The engine reports `done` and, if requested, `irq` when it reaches an end-of-command. It halts with a non-zero `err_code` when it meets an unknown opcode, an event number out of range, or a poll that runs out of attempts. `stop` parks the engine at the next instruction fetch.

Top module: `cqs_top`

## Requirements
- R1: After reset, `busy`, `done`, `irq`, `bus_req` and `ev_flags` are all 0 and `err_code` is 0.
- R2: A write (opcode 0x04) issues one bus write. The address is base[subsys[2:0]] + {offset[15:1],1'b0}, where bits [55:48] are subsys and bits [47:32] are offset, and the default base of window i is i×0x1000. The data is bits [31:0]. `bus_wmask` is all ones when offset bit 0 is 0, and the address and data stay stable while the request waits.
- R3: A mask instruction (opcode 0x01, bit 55 clear) stores bits [31:0] as an inverted mask. Every later write or poll with offset bit 0 set uses the inverse of that stored value, and the stored value persists until the next mask instruction or `start`.
- R4: A poll (opcode 0x08) re-issues its read until (read data & mask) equals (bits [31:0] & mask), then continues with the next word.
- R5: A poll stops with `err_code`=2 once `poll_limit` reads have all failed the compare.
- R6: A mask instruction with bit 55 set loads bits [31:0] into register sop=bits [52:48]. A poll with bit 55 set reads the full address held in register sop.
- R7: A logic instruction (opcode 0x91) writes register offset[3:0]. The left operand is register val[19:16] when bit 54 is set, or else the zero-extended val[31:16]. The right operand is register val[3:0] when bit 53 is set, or else the zero-extended val[15:0]. The sop selects 0 add, 1 subtract, 2 multiply, 3 xor, 4 not (of the left operand), 5 or, 6 and, 7 shift left, 8 shift right. When both bits 54 and 53 are clear, the 32-bit value itself is written.
- R8: A read-indirect (0x90) reads {reg[sop][15:0], val[31:16]} into register offset[3:0]. A write-indirect (0x92) writes to {reg[sop][15:0], offset}, with data taken from register val[19:16] when bit 54 is set and from val otherwise. The masked form (0x93) always applies the stored mask.
- R9: Wait-for-event (0x20) with event = offset uses three value bits: bit 15 waits for the flag, bit 31 enables an update, and bit 16 gives the updated value. `ev_set` pulses set flags. An instruction update overrides a pulse to the same flag in the same cycle.
- R10: A wait-for-event with an event number ≥ NUM_EVENTS stops with `err_code`=3.
- R11: A jump (0x10) goes to the absolute word (val<<SHIFT_PA)/8 when offset bit 0 is 1. When offset bit 0 is 0, it adds the signed amount (val<<SHIFT_PA)/8 to the current word.
- R12: End-of-command (0x40) stops the engine with `done`=1 and `irq`=val[0].
- R13: Any other opcode stops the engine with `err_code`=1 and `done`=0.
- R14: `stop` is taken at the next instruction fetch and returns the engine to idle with `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at word 0 |
| stop | input | 1 | Park at the next fetch |
| poll_limit | input | 16 | Failed poll reads allowed before timeout |
| imem_we | input | 1 | Program memory write enable |
| imem_waddr | input | 6 | Program memory write index |
| imem_wdata | input | 64 | Program word |
| ev_set | input | 16 | Hardware event set pulses |
| bus_req | output | 1 | Bus request, held until acknowledge |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Write data |
| bus_wmask | output | 32 | Bit enables for the write |
| bus_rdata | input | 32 | Read data, valid with acknowledge |
| bus_ack | input | 1 | Transfer complete |
| ev_flags | output | 16 | Current event flags |
| busy | output | 1 | Engine running |
| done | output | 1 | Ended by end-of-command |
| irq | output | 1 | Interrupt from end-of-command |
| err_code | output | 2 | 0 none, 1 opcode, 2 poll timeout, 3 event |

## Verification
Writes are tried with offset bit 0 clear and set, and after a mask has been loaded. This shows whether the mask is applied, whether it persists, and whether address bit 0 is dropped. Polls are run with a direct window and with an indirect register address, against data that matches after several reads or never matches. This separates the compare-with-mask and retry logic from the timeout count. Logic programs chain register and immediate operands through every main sub-op and dump the results with write-indirect, which exposes wrong operand selection. Event, jump and error programs each drive one control path: stalling until a pulse, forward and backward jumps that skip marker writes, and halts on bad opcodes or event numbers.

// File: rtl/cqs_pkg.sv
package cqs_pkg;

  localparam logic [7:0] OP_MASK  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h04;
  localparam logic [7:0] OP_POLL  = 8'h08;
  localparam logic [7:0] OP_JUMP  = 8'h10;
  localparam logic [7:0] OP_WFE   = 8'h20;
  localparam logic [7:0] OP_EOC   = 8'h40;
  localparam logic [7:0] OP_RDI   = 8'h90;
  localparam logic [7:0] OP_LOGIC = 8'h91;
  localparam logic [7:0] OP_WRI   = 8'h92;
  localparam logic [7:0] OP_WRIM  = 8'h93;

  localparam int WFE_WAIT_BIT = 15;
  localparam int WFE_UVAL_BIT = 16;
  localparam int WFE_UPD_BIT  = 31;

  typedef struct packed {
    logic [7:0]  op;
    logic        dst_t;
    logic        src_t;
    logic        arg_t;
    logic [4:0]  sop;
    logic [15:0] off;
    logic [31:0] val;
  } cmd_t;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_OPCODE  = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_EVENT   = 2'd3
  } err_e;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC, S_BUS} state_e;

  function automatic logic [255:0] default_bases();
    logic [255:0] b;
    for (int i = 0; i < 8; i++) b[i*32 +: 32] = 32'(i) << 12;
    return b;
  endfunction

endpackage

// File: rtl/cqs_imem.sv
module cqs_imem #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cqs_regfile.sv
module cqs_regfile #(
  parameter int N = 16,
  parameter int W = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd0,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (we) regs[wa] <= wd;
  end

  assign rd0 = regs[ra0];
  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/cqs_alu.sv
module cqs_alu #(
  parameter int W = 32
) (
  input  logic [4:0]   sop,
  input  logic         pass,
  input  logic [W-1:0] pass_val,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    if (pass) y = pass_val;
    else begin
      unique case (sop)
        5'd0:    y = a + b;
        5'd1:    y = a - b;
        5'd2:    y = W'(a * b);
        5'd3:    y = a ^ b;
        5'd4:    y = ~a;
        5'd5:    y = a | b;
        5'd6:    y = a & b;
        5'd7:    y = a << b[4:0];
        5'd8:    y = a >> b[4:0];
        default: y = '0;
      endcase
    end
  end
endmodule

// File: rtl/cqs_top.sv
module cqs_top
  import cqs_pkg::*;
#(
  parameter int           IMEM_DEPTH  = 64,
  parameter int           NUM_EVENTS  = 16,
  parameter int           NUM_REGS    = 16,
  parameter int           SHIFT_PA    = 3,
  parameter logic [255:0] SUBSYS_BASE = default_bases(),
  localparam int PC_W = $clog2(IMEM_DEPTH),
  localparam int EV_W = $clog2(NUM_EVENTS),
  localparam int RA_W = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  stop,
  input  logic [15:0]           poll_limit,
  input  logic                  imem_we,
  input  logic [PC_W-1:0]       imem_waddr,
  input  logic [63:0]           imem_wdata,
  input  logic [NUM_EVENTS-1:0] ev_set,
  output logic                  bus_req,
  output logic                  bus_we,
  output logic [31:0]           bus_addr,
  output logic [31:0]           bus_wdata,
  output logic [31:0]           bus_wmask,
  input  logic [31:0]           bus_rdata,
  input  logic                  bus_ack,
  output logic [NUM_EVENTS-1:0] ev_flags,
  output logic                  busy,
  output logic                  done,
  output logic                  irq,
  output logic [1:0]            err_code
);
  state_e          state;
  logic [PC_W-1:0] pc;
  logic [63:0]     imem_rdata;
  cmd_t            ir;
  logic [31:0]     mask_q;
  logic [15:0]     poll_cnt;

  logic [31:0] rf_hi, rf_src, rf_arg, alu_a, alu_b, alu_y, rf_wd;
  logic [31:0] sub_base, addr_sub, umask;
  logic        rf_we, ev_bad, ev_go, poll_hit;
  logic [RA_W-1:0] rf_wa;
  logic [EV_W-1:0] ev_idx;

  cqs_imem #(.DEPTH(IMEM_DEPTH), .WIDTH(64)) u_imem (
    .clk(clk), .we(imem_we), .waddr(imem_waddr), .wdata(imem_wdata),
    .raddr(pc), .rdata(imem_rdata)
  );

  assign ir = cmd_t'(imem_rdata);

  cqs_regfile #(.N(NUM_REGS), .W(32)) u_rf (
    .clk(clk), .we(rf_we), .wa(rf_wa), .wd(rf_wd),
    .ra0(ir.sop[RA_W-1:0]), .ra1(ir.val[16 +: RA_W]), .ra2(ir.val[RA_W-1:0]),
    .rd0(rf_hi), .rd1(rf_src), .rd2(rf_arg)
  );

  assign alu_a = ir.src_t ? rf_src : {16'h0, ir.val[31:16]};
  assign alu_b = ir.arg_t ? rf_arg : {16'h0, ir.val[15:0]};

  cqs_alu #(.W(32)) u_alu (
    .sop(ir.sop), .pass(!ir.src_t && !ir.arg_t), .pass_val(ir.val),
    .a(alu_a), .b(alu_b), .y(alu_y)
  );

  // Decode helpers
  always_comb begin
    sub_base = SUBSYS_BASE[32*ir.sop[2:0] +: 32];
    addr_sub = sub_base + {16'h0, ir.off[15:1], 1'b0};
    umask    = ir.off[0] ? ~mask_q : '1;
    ev_idx   = ir.off[EV_W-1:0];
    ev_bad   = ir.off >= 16'(NUM_EVENTS);
    ev_go    = !ir.val[WFE_WAIT_BIT] || ev_q_bit(ev_flags, ev_idx);
    poll_hit = ((bus_rdata ^ ir.val) & umask) == 32'h0;
  end

  function automatic logic ev_q_bit(logic [NUM_EVENTS-1:0] f, logic [EV_W-1:0] i);
    return f[i];
  endfunction

  // Register file write port: executed loads and logic, or read returns
  always_comb begin
    rf_we = 1'b0;
    rf_wa = ir.off[RA_W-1:0];
    rf_wd = alu_y;
    if (state == S_EXEC) begin
      if (ir.op == OP_MASK && ir.dst_t) begin
        rf_we = 1'b1;
        rf_wa = ir.sop[RA_W-1:0];
        rf_wd = ir.val;
      end else if (ir.op == OP_LOGIC) begin
        rf_we = 1'b1;
      end
    end else if (state == S_BUS && bus_ack && ir.op == OP_RDI) begin
      rf_we = 1'b1;
      rf_wd = bus_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      pc        <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      irq       <= 1'b0;
      err_code  <= ERR_NONE;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_wmask <= '0;
      mask_q    <= '0;
      ev_flags  <= '0;
      poll_cnt  <= '0;
    end else begin
      ev_flags <= ev_flags | ev_set;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            pc       <= '0;
            busy     <= 1'b1;
            done     <= 1'b0;
            irq      <= 1'b0;
            err_code <= ERR_NONE;
            mask_q   <= '0;
            state    <= S_FETCH;
          end
        end
        S_FETCH: begin
          poll_cnt <= '0;
          if (stop) begin
            busy  <= 1'b0;
            state <= S_IDLE;
          end else begin
            state <= S_EXEC;
          end
        end
        S_EXEC: begin
          unique case (ir.op)
            OP_MASK: begin
              if (!ir.dst_t) mask_q <= ir.val;
              pc    <= pc + 1'b1;
              state <= S_FETCH;
            end
            OP_WRITE: begin
              bus_req   <= 1'b1;
              bus_we    <= 1'b1;
              bus_addr  <= addr_sub;
              bus_wdata <= ir.val;
              bus_wmask <= umask;
              state     <= S_BUS;
            end
            OP_POLL: begin
              bus_req  <= 1'b1;
              bus_we   <= 1'b0;
              bus_addr <= ir.dst_t ? rf_hi : addr_sub;
              state    <= S_BUS;
            end
            OP_RDI: begin
              bus_req  <= 1'b1;
              bus_we   <= 1'b0;
              bus_addr <= {rf_hi[15:0], ir.val[31:16]};
              state    <= S_BUS;
            end
            OP_WRI, OP_WRIM: begin
              bus_req   <= 1'b1;
              bus_we    <= 1'b1;
              bus_addr  <= {rf_hi[15:0], ir.off};
              bus_wdata <= ir.src_t ? rf_src : ir.val;
              bus_wmask <= (ir.op == OP_WRIM) ? ~mask_q : '1;
              state     <= S_BUS;
            end
            OP_LOGIC: begin
              pc    <= pc + 1'b1;
              state <= S_FETCH;
            end
            OP_JUMP: begin
              if (ir.off[0]) pc <= PC_W'((ir.val << SHIFT_PA) >> 3);
              else pc <= pc + PC_W'($signed(ir.val << SHIFT_PA) >>> 3);
              state <= S_FETCH;
            end
            OP_WFE: begin
              if (ev_bad) begin
                err_code <= ERR_EVENT;
                busy     <= 1'b0;
                state    <= S_IDLE;
              end else if (ev_go) begin
                if (ir.val[WFE_UPD_BIT]) ev_flags[ev_idx] <= ir.val[WFE_UVAL_BIT];
                pc    <= pc + 1'b1;
                state <= S_FETCH;
              end
            end
            OP_EOC: begin
              done  <= 1'b1;
              irq   <= ir.val[0];
              busy  <= 1'b0;
              state <= S_IDLE;
            end
            default: begin
              err_code <= ERR_OPCODE;
              busy     <= 1'b0;
              state    <= S_IDLE;
            end
          endcase
        end
        S_BUS: begin
          if (bus_ack) begin
            bus_req <= 1'b0;
            if (ir.op != OP_POLL || poll_hit) begin
              pc    <= pc + 1'b1;
              state <= S_FETCH;
            end else if (poll_cnt + 16'd1 >= poll_limit) begin
              err_code <= ERR_TIMEOUT;
              busy     <= 1'b0;
              state    <= S_IDLE;
            end else begin
              poll_cnt <= poll_cnt + 16'd1;
              state    <= S_EXEC;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata))); // R2
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
    (busy && state == S_BUS) |-> (poll_cnt == 16'd0 || poll_cnt < poll_limit)); // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R12
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    irq |-> done); // R12
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst)
    (err_code != 2'd0) |-> (!busy && !done)); // R13
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req); // R14
endmodule

// File: tb/cqs_top_tb.sv
module cqs_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, stop = 1'b0;
  logic [15:0] poll_limit = 16'd100;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_waddr = '0;
  logic [63:0] imem_wdata = '0;
  logic [15:0] ev_set = '0;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_wmask;
  logic [31:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;
  logic [15:0] ev_flags;
  logic        busy, done, irq;
  logic [1:0]  err_code;

  int total = 0, bad = 0;

  cqs_top u_dut (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .poll_limit(poll_limit),
    .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
    .ev_set(ev_set), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .ev_flags(ev_flags), .busy(busy), .done(done),
    .irq(irq), .err_code(err_code)
  );

  always #4 clk = ~clk;

  // Bus responder and transfer log
  logic        clr = 1'b0;
  logic [31:0] w_addr [8];
  logic [31:0] w_data [8];
  logic [31:0] w_mask [8];
  int          w_cnt = 0, r_cnt = 0, p_seen = 0;
  logic [31:0] p_addr = 32'hFFFF_FFFF, p_good = '0, p_bad = '0;
  int          p_after = 0;

  always @(posedge clk) begin
    if (rst || clr) begin
      bus_ack <= 1'b0;
      w_cnt   <= 0;
      r_cnt   <= 0;
      p_seen  <= 0;
    end else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_we) begin
        if (w_cnt < 8) begin
          w_addr[w_cnt] <= bus_addr;
          w_data[w_cnt] <= bus_wdata;
          w_mask[w_cnt] <= bus_wmask;
        end
        w_cnt <= w_cnt + 1;
      end else begin
        r_cnt <= r_cnt + 1;
        if (bus_addr == p_addr) begin
          bus_rdata <= (p_seen >= p_after) ? p_good : p_bad;
          p_seen    <= p_seen + 1;
        end else begin
          bus_rdata <= bus_addr ^ 32'hA5A5_0000;
        end
      end
    end else begin
      bus_ack <= 1'b0;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: run hung act=%0d exp<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [63:0] ins(logic [7:0] op, logic [7:0] mid,
                                      logic [15:0] off, logic [31:0] val);
    return {op, mid, off, val};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  task automatic put(int idx, logic [63:0] w);
    @(negedge clk);
    imem_we = 1'b1; imem_waddr = 6'(idx); imem_wdata = w;
    @(negedge clk);
    imem_we = 1'b0;
  endtask

  task automatic clear_log();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic run();
    clear_log();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    eq("R1", "busy", 32'(busy), 0);
    eq("R1", "done", 32'(done), 0);
    eq("R1", "irq", 32'(irq), 0);
    eq("R1", "bus_req", 32'(bus_req), 0);
    eq("R1", "err", 32'(err_code), 0);
    eq("R1", "ev_flags", 32'(ev_flags), 0);
  endtask

  task automatic t_write();
    put(0, ins(8'h04, 8'h02, 16'h0010, 32'h1234_5678));
    put(1, ins(8'h40, 8'h00, 16'h0000, 32'h1));
    run();
    eq("R2", "write count", 32'(w_cnt), 1);
    eq("R2", "addr", w_addr[0], 32'h0000_2010);
    eq("R2", "data", w_data[0], 32'h1234_5678);
    eq("R2", "mask", w_mask[0], 32'hFFFF_FFFF);
    eq("R12", "done", 32'(done), 1);
    eq("R12", "irq", 32'(irq), 1);
  endtask

  task automatic t_mask();
    put(0, ins(8'h01, 8'h00, 16'h0000, 32'hFFFF_00FF));
    put(1, ins(8'h04, 8'h01, 16'h0021, 32'hAABB_CCDD));
    put(2, ins(8'h04, 8'h01, 16'h0031, 32'h1));
    put(3, ins(8'h04, 8'h01, 16'h0040, 32'h2));
    put(4, ins(8'h40, 8'h00, 16'h0000, 32'h0));
    run();
    eq("R3", "write count", 32'(w_cnt), 3);
    eq("R3", "addr bit0 dropped", w_addr[0], 32'h0000_1020);
    eq("R3", "mask applied", w_mask[0], 32'h0000_FF00);
    eq("R3", "mask sticky", w_mask[1], 32'h0000_FF00);
    eq("R3", "mask off", w_mask[2], 32'hFFFF_FFFF);
    eq("R12", "irq clear when bit0=0", 32'(irq), 0);
  endtask

  task automatic t_poll();
    p_addr = 32'h0000_3004; p_bad = 32'h10; p_good = 32'h25; p_after = 3;
    put(0, ins(8'h01, 8'h00, 16'h0000, 32'hFFFF_FFF0));
    put(1, ins(8'h08, 8'h03, 16'h0005, 32'h5));
    put(2, ins(8'h40, 8'h00, 16'h0000, 32'h0));
    run();
    eq("R4", "reads until match", 32'(r_cnt), 4);
    eq("R4", "done", 32'(done), 1);
    eq("R4", "err", 32'(err_code), 0);
  endtask

  task automatic t_timeout();
    poll_limit = 16'd4;
    p_addr = 32'h0000_3004; p_bad = 32'h2; p_good = 32'h1; p_after = 1000;
    put(0, ins(8'h08, 8'h03, 16'h0004, 32'h1));
    put(1, ins(8'h40, 8'h00, 16'h0000, 32'h0));
    run();
    eq("R5", "err timeout", 32'(err_code), 2);
    eq("R5", "reads", 32'(r_cnt), 4);
    eq("R5", "busy", 32'(busy), 0);
    poll_limit = 16'd100;
  endtask

  task automatic t_indirect_poll();
    p_addr = 32'h0000_7008; p_good = 32'h99; p_bad = 32'h0; p_after = 0;
    put(0, ins(8'h01, 8'h8F, 16'h0000, 32'h0000_7008));
    put(1, ins(8'h08, 8'h8F, 16'h0000, 32'h99));
    put(2, ins(8'h92, 8'h4F, 16'h0040, {16'd15, 16'h0}));
    put(3, ins(8'h40, 8'h00, 16'h0000, 32'h0));
    run();
    eq("R6", "poll reads", 32'(r_cnt), 1);
    eq("R6", "reg addr write", w_addr[0], 32'h7008_0040);
    eq("R6", "reg data", w_data[0], 32'h0000_7008);
  endtask

  task automatic t_logic();
    logic [31:0] exp [8];
    put(0,  ins(8'h91, 8'h80, 16'd0, 32'h0));
    put(1,  ins(8'h91, 8'h80, 16'd1, 32'h1234_0005));
    put(2,  ins(8'h91, 8'hC0, 16'd2, {16'd1, 16'd3}));
    put(3,  ins(8'h91, 8'hE3, 16'd3, {16'd2, 16'd1}));
    put(4,  ins(8'h91, 8'hC7, 16'd4, {16'd1, 16'd4}));
    put(5,  ins(8'h91, 8'hE1, 16'd5, {16'd1, 16'd2}));
    put(6,  ins(8'h91, 8'hC2, 16'd6, {16'd1, 16'd3}));
    put(7,  ins(8'h91, 8'hC4, 16'd7, {16'd1, 16'd0}));
    put(8,  ins(8'h91, 8'hC8, 16'd10, {16'd1, 16'd8}));
    for (int k = 0; k < 7; k++) begin
      int r;
      r = (k == 6) ? 10 : k + 1;
      put(9 + k, ins(8'h92, 8'h40, 16'(16'h100 + k), {16'(r), 16'h0}));
    end
    put(16, ins(8'h40, 8'h00, 16'h0000, 32'h0));
    exp[0] = 32'h1234_0005; exp[1] = 32'h1234_0008; exp[2] = 32'h0000_000D;
    exp[3] = 32'h2340_0050; exp[4] = 32'hFFFF_FFFD; exp[5] = 32'h369C_000F;
    exp[6] = 32'h0012_3400;
    run();
    eq("R7", "write count", 32'(w_cnt), 7);
    for (int k = 0; k < 7; k++) begin
      eq("R7", $sformatf("result %0d", k), w_data[k], exp[k]);
    end
    eq("R7", "dump addr", w_addr[6], 32'h0000_0106);
  endtask

  task automatic t_rdwr_ind();
    put(0, ins(8'h91, 8'h80, 16'd8, 32'h0000_00AB));
    put(1, ins(8'h90, 8'h88, 16'd9, {16'h0044, 16'h0}));
    put(2, ins(8'h92, 8'h40, 16'h0200, {16'd9, 16'h0}));
    put(3, ins(8'h01, 8'h00, 16'h0000, 32'hFF00_FFFF));
    put(4, ins(8'h93, 8'h00, 16'h0204, 32'hCAFE_F00D));
    put(5, ins(8'h40, 8'h00, 16'h0000, 32'h0));
    run();
    eq("R8", "read count", 32'(r_cnt), 1);
    eq("R8", "read data stored", w_data[0], 32'hA50E_0044);
    eq("R8", "masked indirect addr", w_addr[1], 32'h0000_0204);
    eq("R8", "masked indirect mask", w_mask[1], 32'h00FF_0000);
    eq("R8", "masked indirect data", w_data[1], 32'hCAFE_F00D);
  endtask

  task automatic t_events();
    @(negedge clk); ev_set = 16'h0080;
    @(negedge clk); ev_set = 16'h0000;
    eq("R9", "hw set pulse", 32'(ev_flags), 32'h80);
    put(0, ins(8'h20, 8'h00, 16'd3, 32'h0000_8000));
    put(1, ins(8'h04, 8'h00, 16'h0050, 32'h77));
    put(2, ins(8'h20, 8'h00, 16'd5, 32'h8001_0000));
    put(3, ins(8'h20, 8'h00, 16'd3, 32'h8000_0000));
    put(4, ins(8'h20, 8'h00, 16'd7, 32'h8001_8000));
    put(5, ins(8'h40, 8'h00, 16'h0000, 32'h0));
    clear_log();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    eq("R9", "stalled busy", 32'(busy), 1);
    eq("R9", "stalled no write", 32'(w_cnt), 0);
    ev_set = 16'h0008;
    @(negedge clk); ev_set = 16'h0000;
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    eq("R9", "write after wait", 32'(w_cnt), 1);
    eq("R9", "flags set/clear/acquire", 32'(ev_flags), 32'h00A0);
    eq("R9", "done", 32'(done), 1);
  endtask

  task automatic t_bad_event();
    put(0, ins(8'h20, 8'h00, 16'd16, 32'h0000_8000));
    put(1, ins(8'h40, 8'h00, 16'h0000, 32'h0));
    run();
    eq("R10", "err event", 32'(err_code), 3);
    eq("R10", "not done", 32'(done), 0);
  endtask

  task automatic t_jump();
    put(0, ins(8'h10, 8'h00, 16'h0001, 32'd4));
    put(1, ins(8'h04, 8'h00, 16'h0060, 32'h11));
    put(2, ins(8'h40, 8'h00, 16'h0000, 32'h1));
    put(3, ins(8'h04, 8'h00, 16'h0070, 32'h22));
    put(4, ins(8'h10, 8'h00, 16'h0000, 32'hFFFF_FFFD));
    run();
    eq("R11", "write count", 32'(w_cnt), 1);
    eq("R11", "landed write", w_addr[0], 32'h0000_0060);
    eq("R11", "done", 32'(done), 1);
  endtask

  task automatic t_bad_op();
    put(0, ins(8'h55, 8'h00, 16'h0000, 32'h0));
    run();
    eq("R13", "err opcode", 32'(err_code), 1);
    eq("R13", "busy", 32'(busy), 0);
    eq("R13", "done", 32'(done), 0);
  endtask

  task automatic t_stop();
    put(0, ins(8'h10, 8'h00, 16'h0000, 32'h0));
    clear_log();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    eq("R14", "looping busy", 32'(busy), 1);
    stop = 1'b1;
    for (int i = 0; i < 10 && busy; i++) @(negedge clk);
    stop = 1'b0;
    eq("R14", "stopped", 32'(busy), 0);
    eq("R14", "done after stop", 32'(done), 0);
    eq("R14", "err after stop", 32'(err_code), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write();
    t_mask();
    t_poll();
    t_timeout();
    t_indirect_poll();
    t_logic();
    t_rdwr_ind();
    t_events();
    t_bad_event();
    t_jump();
    t_bad_op();
    t_stop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule